// File: doc/BRIEF.md
# Save-Area Frame Page Walker

This block locates the save frame that a thread will use on entry to a protected region and proves that every page of that frame may be used. The frame address is derived from the save-area offset and the region base. It is then moved forward by the frame size times the current frame index. Starting there, the walker requests metadata for one 4 KiB page at a time, over a valid/ready request channel and a one-beat response channel. Each returned record is checked against a set of per-page rules, and the physical page number of each accepted page is kept.

Once the frame pages are covered, the walker computes the address of the register-save area at the top of the frame. That page gets the same metadata checks. In 32-bit operation, the block also checks that the last byte of the register area falls inside the data segment limit. The first failing check ends the walk at once and reports a page fault or a protection fault, together with the address concerned. The surrounding control logic starts a walk with a one-cycle pulse and waits for the done pulse.

Top module: `sfw_walker`

## Requirements
- R1: The first page requested is the page of frame = save_ofs_i + region_base_i + 4096 × frame_pages_i × frame_idx_i (truncated to ADDR_W bits). lk_req_page_o carries address bits [ADDR_W-1:12].
- R2: Frame pages are requested in ascending order, one page apart. The count is floor(xstate_size_i / 4096) + 1, capped at MAX_PAGES (default 16).
- R3: A page passes only if all of the following hold in its response: lk_rsp_prot_i=1, lk_rsp_present_i=1, lk_rsp_blocked_i=0, lk_rsp_pending_i=0, lk_rsp_modified_i=0, lk_rsp_regular_i=1, lk_rsp_rd_i=1 and lk_rsp_wr_i=1. Otherwise pf_fault_o is set and fault_addr_o holds that page's linear address.
- R4: A page also fails with a page fault when lk_rsp_lin_page_i differs from the requested page, or when lk_rsp_owner_i differs from owner_id_i.
- R5: After the first fault no further request is issued. pf_fault_o and gp_fault_o are never both set.
- R6: After the last frame page, the page of gpr = frame + 4096 × frame_pages_i − GPR_BYTES (default 184) is requested and checked by the rules of R3 and R4. If it fails, fault_addr_o holds gpr. If it passes, gpr_ppn_o holds its lk_rsp_ppn_i.
- R7: When mode32_i=1 and gpr + GPR_BYTES − 1 > ds_limit_i, gp_fault_o is set and fault_addr_o holds gpr. When mode32_i=0 the limit is not checked.
- R8: page_count_o is the number of frame pages that passed. Slot k of pa_list_o (bits [k×PPN_W +: PPN_W]) holds the lk_rsp_ppn_i of the k-th frame page. Unused slots read 0.
- R9: lk_req_valid_o and lk_req_page_o hold steady until lk_req_ready_i. Each page is requested once. The next request follows only after the response to the previous one.
- R10: done_o pulses for exactly one cycle at the end of a walk. Results hold until the next start. start_i is ignored while a walk is in progress.
- R11: After reset there is no request, done_o, busy_o, both fault flags, page_count_o and every slot are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start a walk (taken when idle) |
| mode32_i | input | 1 | 1 = 32-bit operation, enables the segment check |
| save_ofs_i | input | ADDR_W | Save-area offset inside the region |
| region_base_i | input | ADDR_W | Region base linear address |
| frame_pages_i | input | FSZ_W | Frame size in pages |
| frame_idx_i | input | IDX_W | Current frame index |
| xstate_size_i | input | XS_W | Extended-state size in bytes |
| owner_id_i | input | OWN_W | Owning region identifier of the thread record |
| ds_limit_i | input | SEG_W | Data segment limit |
| lk_req_valid_o | output | 1 | Metadata request valid |
| lk_req_ready_i | input | 1 | Metadata request accepted |
| lk_req_page_o | output | ADDR_W-12 | Linear page number requested |
| lk_rsp_valid_i | input | 1 | Response beat |
| lk_rsp_prot_i | input | 1 | Page lies in protected memory |
| lk_rsp_present_i | input | 1 | Metadata entry valid |
| lk_rsp_blocked_i | input | 1 | Page blocked |
| lk_rsp_pending_i | input | 1 | Page pending |
| lk_rsp_modified_i | input | 1 | Page modified |
| lk_rsp_regular_i | input | 1 | Page type is regular |
| lk_rsp_rd_i | input | 1 | Readable |
| lk_rsp_wr_i | input | 1 | Writable |
| lk_rsp_lin_page_i | input | ADDR_W-12 | Linear page recorded in the metadata |
| lk_rsp_owner_i | input | OWN_W | Owning region recorded in the metadata |
| lk_rsp_ppn_i | input | PPN_W | Physical page number |
| busy_o | output | 1 | Walk in progress |
| done_o | output | 1 | One-cycle end-of-walk pulse |
| pf_fault_o | output | 1 | Page fault result |
| gp_fault_o | output | 1 | Protection fault result |
| fault_addr_o | output | ADDR_W | Address tied to the fault |
| page_count_o | output | clog2(MAX_PAGES+1) | Frame pages accepted |
| pa_list_o | output | MAX_PAGES×PPN_W | Captured physical page numbers |
| gpr_ppn_o | output | PPN_W | Physical page of the register area |

## Verification
The bench targets the page-count edges: sizes of 0, 4095, 4096, exactly MAX_PAGES pages, and beyond the cap. A wrong rounding or a missing cap would show up as an extra or a missing request on the checked request stream. Every metadata field, the linear-page match and the owner match are corrupted in turn at different page positions, including the register-area page. A design that kept walking after a fault, or reported the wrong address, would issue an unexpected request or a mismatched fault_addr_o. The segment limit is probed at exactly the last byte and one below it, in both modes, where an off-by-one comparison would flip the protection fault. Ready backpressure, response delays and a start pulse during a walk catch a request that moves before acceptance, a duplicated request, or a walk restarted in mid-flight.

// File: rtl/sfw_pkg.sv
package sfw_pkg;

   localparam int PG_SH = 12;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_REQ,
      ST_RSP,
      ST_DONE
   } sfw_state_e;

   typedef struct packed {
      logic in_prot;
      logic present;
      logic blocked;
      logic pending;
      logic modified;
      logic regular;
      logic rd;
      logic wr;
   } sfw_meta_t;

endpackage

// File: rtl/sfw_addr_gen.sv
module sfw_addr_gen
   import sfw_pkg::*;
#(
   parameter int ADDR_W    = 48,
   parameter int FSZ_W     = 8,
   parameter int IDX_W     = 8,
   parameter int XS_W      = 20,
   parameter int MAX_PAGES = 16,
   parameter int GPR_BYTES = 184,
   parameter int CNT_W     = 5
) (
   input  logic [ADDR_W-1:0] save_ofs_i,
   input  logic [ADDR_W-1:0] base_i,
   input  logic [FSZ_W-1:0]  fsz_i,
   input  logic [IDX_W-1:0]  idx_i,
   input  logic [XS_W-1:0]   xsize_i,
   output logic [ADDR_W-1:0] frame_addr_o,
   output logic [ADDR_W-1:0] gpr_addr_o,
   output logic [CNT_W-1:0]  npages_o
);

   localparam int     PROD_W  = FSZ_W + IDX_W;
   localparam int     RAW_W   = XS_W - PG_SH + 1;
   localparam longint MAX_RAW = longint'(1) << (XS_W - PG_SH);

   logic [PROD_W-1:0] prod;
   logic [ADDR_W-1:0] prod_bytes;
   logic [ADDR_W-1:0] span_bytes;
   logic [RAW_W-1:0]  raw_pages;

   // frame index times frame size, scaled to bytes
   assign prod       = PROD_W'(fsz_i) * PROD_W'(idx_i);
   assign prod_bytes = ADDR_W'(prod) << PG_SH;
   assign span_bytes = ADDR_W'(fsz_i) << PG_SH;

   assign frame_addr_o = save_ofs_i + base_i + prod_bytes;
   assign gpr_addr_o   = frame_addr_o + span_bytes - ADDR_W'(GPR_BYTES);

   // inclusive walk: whole pages in the size, plus the starting page
   assign raw_pages = RAW_W'(xsize_i >> PG_SH) + RAW_W'(1);

   generate
      if (MAX_RAW > longint'(MAX_PAGES)) begin : g_clamp
         localparam int CMP_W = (RAW_W > CNT_W) ? RAW_W : CNT_W;
         logic [CMP_W-1:0] raw_x;
         assign raw_x    = CMP_W'(raw_pages);
         assign npages_o = (raw_x > CMP_W'(MAX_PAGES)) ? CNT_W'(MAX_PAGES) : CNT_W'(raw_x);
      end else begin : g_direct
         assign npages_o = CNT_W'(raw_pages);
      end
   endgenerate

endmodule

// File: rtl/sfw_page_check.sv
module sfw_page_check
   import sfw_pkg::*;
#(
   parameter int LPG_W = 36,
   parameter int OWN_W = 16
) (
   input  sfw_meta_t         meta_i,
   input  logic [LPG_W-1:0]  lin_page_i,
   input  logic [LPG_W-1:0]  exp_page_i,
   input  logic [OWN_W-1:0]  owner_i,
   input  logic [OWN_W-1:0]  exp_owner_i,
   output logic              pass_o
);

   logic flags_ok;
   logic ident_ok;

   always_comb begin
      flags_ok = meta_i.in_prot & meta_i.present & ~meta_i.blocked & ~meta_i.pending
               & ~meta_i.modified & meta_i.regular & meta_i.rd & meta_i.wr;
      ident_ok = (lin_page_i == exp_page_i) && (owner_i == exp_owner_i);
      pass_o   = flags_ok & ident_ok;
   end

endmodule

// File: rtl/sfw_pa_store.sv
module sfw_pa_store #(
   parameter int SLOTS = 16,
   parameter int PPN_W = 28,
   parameter int CNT_W = 5
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   clr_i,
   input  logic                   wr_en_i,
   input  logic [CNT_W-1:0]       wr_idx_i,
   input  logic [PPN_W-1:0]       wr_ppn_i,
   output logic [SLOTS*PPN_W-1:0] list_o
);

   generate
      for (genvar s = 0; s < SLOTS; s++) begin : g_slot
         logic [PPN_W-1:0] slot_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               slot_q <= '0;
            end else if (clr_i) begin
               slot_q <= '0;
            end else if (wr_en_i && (wr_idx_i == CNT_W'(s))) begin
               slot_q <= wr_ppn_i;
            end
         end
         assign list_o[s*PPN_W +: PPN_W] = slot_q;
      end
   endgenerate

   // a capture never targets a slot beyond the array
   assert_slot_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_i |-> (int'(wr_idx_i) < SLOTS));

endmodule

// File: rtl/sfw_walker.sv
module sfw_walker
   import sfw_pkg::*;
#(
   parameter int ADDR_W    = 48,
   parameter int FSZ_W     = 8,
   parameter int IDX_W     = 8,
   parameter int XS_W      = 20,
   parameter int OWN_W     = 16,
   parameter int SEG_W     = 32,
   parameter int PPN_W     = 28,
   parameter int MAX_PAGES = 16,
   parameter int GPR_BYTES = 184
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            start_i,
   input  logic                            mode32_i,
   input  logic [ADDR_W-1:0]               save_ofs_i,
   input  logic [ADDR_W-1:0]               region_base_i,
   input  logic [FSZ_W-1:0]                frame_pages_i,
   input  logic [IDX_W-1:0]                frame_idx_i,
   input  logic [XS_W-1:0]                 xstate_size_i,
   input  logic [OWN_W-1:0]                owner_id_i,
   input  logic [SEG_W-1:0]                ds_limit_i,
   output logic                            lk_req_valid_o,
   input  logic                            lk_req_ready_i,
   output logic [ADDR_W-PG_SH-1:0]         lk_req_page_o,
   input  logic                            lk_rsp_valid_i,
   input  logic                            lk_rsp_prot_i,
   input  logic                            lk_rsp_present_i,
   input  logic                            lk_rsp_blocked_i,
   input  logic                            lk_rsp_pending_i,
   input  logic                            lk_rsp_modified_i,
   input  logic                            lk_rsp_regular_i,
   input  logic                            lk_rsp_rd_i,
   input  logic                            lk_rsp_wr_i,
   input  logic [ADDR_W-PG_SH-1:0]         lk_rsp_lin_page_i,
   input  logic [OWN_W-1:0]                lk_rsp_owner_i,
   input  logic [PPN_W-1:0]                lk_rsp_ppn_i,
   output logic                            busy_o,
   output logic                            done_o,
   output logic                            pf_fault_o,
   output logic                            gp_fault_o,
   output logic [ADDR_W-1:0]               fault_addr_o,
   output logic [$clog2(MAX_PAGES+1)-1:0]  page_count_o,
   output logic [MAX_PAGES*PPN_W-1:0]      pa_list_o,
   output logic [PPN_W-1:0]                gpr_ppn_o
);

   localparam int              LPG_W      = ADDR_W - PG_SH;
   localparam int              CNT_W      = $clog2(MAX_PAGES + 1);
   localparam logic [ADDR_W-1:0] PAGE_BYTES = ADDR_W'(1) << PG_SH;

   initial begin
      if (XS_W <= PG_SH || (XS_W - PG_SH) > 30)
         $fatal(1, "sfw_walker: XS_W must lie between 13 and 42");
      if (ADDR_W <= PG_SH + 1 || SEG_W > ADDR_W)
         $fatal(1, "sfw_walker: ADDR_W too small for page or segment width");
      if (MAX_PAGES < 1)
         $fatal(1, "sfw_walker: MAX_PAGES must be at least 1");
      if (GPR_BYTES < 1 || GPR_BYTES > (1 << PG_SH))
         $fatal(1, "sfw_walker: GPR_BYTES must fit inside one page");
   end

   sfw_state_e          state_q;
   logic                phase_gpr_q;
   logic [ADDR_W-1:0]   cur_addr_q;
   logic [ADDR_W-1:0]   gpr_addr_q;
   logic [CNT_W-1:0]    npages_q;
   logic [CNT_W-1:0]    cnt_q;
   logic [OWN_W-1:0]    owner_q;
   logic                mode32_q;
   logic [SEG_W-1:0]    ds_limit_q;
   logic                pf_q;
   logic                gp_q;
   logic [ADDR_W-1:0]   fault_addr_q;
   logic [PPN_W-1:0]    gpr_ppn_q;

   logic [ADDR_W-1:0]   frame_addr_w;
   logic [ADDR_W-1:0]   gpr_addr_w;
   logic [CNT_W-1:0]    npages_w;
   sfw_meta_t           meta_w;
   logic                pass_w;
   logic [ADDR_W-1:0]   gpr_last_w;
   logic                seg_bad_w;
   logic                last_frame_w;
   logic                rsp_take_w;
   logic                store_en_w;
   logic                start_take_w;

   sfw_addr_gen #(
      .ADDR_W    (ADDR_W),
      .FSZ_W     (FSZ_W),
      .IDX_W     (IDX_W),
      .XS_W      (XS_W),
      .MAX_PAGES (MAX_PAGES),
      .GPR_BYTES (GPR_BYTES),
      .CNT_W     (CNT_W)
   ) addr_gen_i (
      .save_ofs_i   (save_ofs_i),
      .base_i       (region_base_i),
      .fsz_i        (frame_pages_i),
      .idx_i        (frame_idx_i),
      .xsize_i      (xstate_size_i),
      .frame_addr_o (frame_addr_w),
      .gpr_addr_o   (gpr_addr_w),
      .npages_o     (npages_w)
   );

   always_comb begin
      meta_w.in_prot  = lk_rsp_prot_i;
      meta_w.present  = lk_rsp_present_i;
      meta_w.blocked  = lk_rsp_blocked_i;
      meta_w.pending  = lk_rsp_pending_i;
      meta_w.modified = lk_rsp_modified_i;
      meta_w.regular  = lk_rsp_regular_i;
      meta_w.rd       = lk_rsp_rd_i;
      meta_w.wr       = lk_rsp_wr_i;
   end

   sfw_page_check #(
      .LPG_W (LPG_W),
      .OWN_W (OWN_W)
   ) page_check_i (
      .meta_i      (meta_w),
      .lin_page_i  (lk_rsp_lin_page_i),
      .exp_page_i  (cur_addr_q[ADDR_W-1:PG_SH]),
      .owner_i     (lk_rsp_owner_i),
      .exp_owner_i (owner_q),
      .pass_o      (pass_w)
   );

   assign gpr_last_w   = gpr_addr_q + ADDR_W'(GPR_BYTES - 1);
   assign seg_bad_w    = gpr_last_w > ADDR_W'(ds_limit_q);
   assign last_frame_w = ({1'b0, cnt_q} + 1'b1) == {1'b0, npages_q};
   assign rsp_take_w   = (state_q == ST_RSP) && lk_rsp_valid_i;
   assign store_en_w   = rsp_take_w && pass_w && !phase_gpr_q;
   assign start_take_w = (state_q == ST_IDLE) && start_i;

   sfw_pa_store #(
      .SLOTS (MAX_PAGES),
      .PPN_W (PPN_W),
      .CNT_W (CNT_W)
   ) pa_store_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr_i    (start_take_w),
      .wr_en_i  (store_en_w),
      .wr_idx_i (cnt_q),
      .wr_ppn_i (lk_rsp_ppn_i),
      .list_o   (pa_list_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q      <= ST_IDLE;
         phase_gpr_q  <= 1'b0;
         cur_addr_q   <= '0;
         gpr_addr_q   <= '0;
         npages_q     <= '0;
         cnt_q        <= '0;
         owner_q      <= '0;
         mode32_q     <= 1'b0;
         ds_limit_q   <= '0;
         pf_q         <= 1'b0;
         gp_q         <= 1'b0;
         fault_addr_q <= '0;
         gpr_ppn_q    <= '0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (start_i) begin
                  cur_addr_q   <= frame_addr_w;
                  gpr_addr_q   <= gpr_addr_w;
                  npages_q     <= npages_w;
                  cnt_q        <= '0;
                  phase_gpr_q  <= 1'b0;
                  owner_q      <= owner_id_i;
                  mode32_q     <= mode32_i;
                  ds_limit_q   <= ds_limit_i;
                  pf_q         <= 1'b0;
                  gp_q         <= 1'b0;
                  fault_addr_q <= '0;
                  gpr_ppn_q    <= '0;
                  state_q      <= ST_REQ;
               end
            end
            ST_REQ: begin
               if (lk_req_ready_i) state_q <= ST_RSP;
            end
            ST_RSP: begin
               if (lk_rsp_valid_i) begin
                  if (!pass_w) begin
                     pf_q         <= 1'b1;
                     fault_addr_q <= cur_addr_q;
                     state_q      <= ST_DONE;
                  end else if (!phase_gpr_q) begin
                     cnt_q   <= cnt_q + 1'b1;
                     state_q <= ST_REQ;
                     if (last_frame_w) begin
                        phase_gpr_q <= 1'b1;
                        cur_addr_q  <= gpr_addr_q;
                     end else begin
                        cur_addr_q  <= cur_addr_q + PAGE_BYTES;
                     end
                  end else begin
                     gpr_ppn_q <= lk_rsp_ppn_i;
                     if (mode32_q && seg_bad_w) begin
                        gp_q         <= 1'b1;
                        fault_addr_q <= cur_addr_q;
                     end
                     state_q <= ST_DONE;
                  end
               end
            end
            ST_DONE: state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign lk_req_valid_o = (state_q == ST_REQ);
   assign lk_req_page_o  = cur_addr_q[ADDR_W-1:PG_SH];
   assign busy_o         = (state_q == ST_REQ) || (state_q == ST_RSP);
   assign done_o         = (state_q == ST_DONE);
   assign pf_fault_o     = pf_q;
   assign gp_fault_o     = gp_q;
   assign fault_addr_o   = fault_addr_q;
   assign page_count_o   = cnt_q;
   assign gpr_ppn_o      = gpr_ppn_q;

   // request is held, unchanged, until accepted
   assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_req_valid_o && !lk_req_ready_i) |=> (lk_req_valid_o && $stable(lk_req_page_o)));

   // one fault kind at most
   assert_fault_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({pf_fault_o, gp_fault_o}));

   // a faulted walk issues nothing further
   assert_no_req_after_fault_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (pf_fault_o || gp_fault_o) |-> !lk_req_valid_o);

   // completion is a single-cycle pulse
   assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // accepted page count never passes the cap
   assert_count_cap_R2: assert property (@(posedge clk) disable iff (!rst_n)
      int'(page_count_o) <= MAX_PAGES);

   // the segment fault only arises in 32-bit operation
   assert_gp_mode_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gp_fault_o) |-> mode32_q);

endmodule

// File: tb/sfw_walker_tb.sv
`timescale 1ns/1ps
module sfw_walker_tb_top;

   localparam int ADDR_W    = 48;
   localparam int FSZ_W     = 8;
   localparam int IDX_W     = 8;
   localparam int XS_W      = 20;
   localparam int OWN_W     = 16;
   localparam int SEG_W     = 32;
   localparam int PPN_W     = 28;
   localparam int MAX_PAGES = 16;
   localparam int GPR_BYTES = 184;
   localparam int CNT_W     = $clog2(MAX_PAGES + 1);
   localparam int LPG_W     = ADDR_W - 12;
   localparam longint unsigned AMASK = (64'h1 << ADDR_W) - 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic                   start_i = 0, mode32_i = 0;
   logic [ADDR_W-1:0]      save_ofs_i = '0, region_base_i = '0;
   logic [FSZ_W-1:0]       frame_pages_i = '0;
   logic [IDX_W-1:0]       frame_idx_i = '0;
   logic [XS_W-1:0]        xstate_size_i = '0;
   logic [OWN_W-1:0]       owner_id_i = '0;
   logic [SEG_W-1:0]       ds_limit_i = '0;
   logic                   lk_req_valid_o, lk_req_ready_i = 0;
   logic [LPG_W-1:0]       lk_req_page_o;
   logic                   lk_rsp_valid_i = 0, lk_rsp_prot_i = 0, lk_rsp_present_i = 0;
   logic                   lk_rsp_blocked_i = 0, lk_rsp_pending_i = 0, lk_rsp_modified_i = 0;
   logic                   lk_rsp_regular_i = 0, lk_rsp_rd_i = 0, lk_rsp_wr_i = 0;
   logic [LPG_W-1:0]       lk_rsp_lin_page_i = '0;
   logic [OWN_W-1:0]       lk_rsp_owner_i = '0;
   logic [PPN_W-1:0]       lk_rsp_ppn_i = '0;
   logic                   busy_o, done_o, pf_fault_o, gp_fault_o;
   logic [ADDR_W-1:0]      fault_addr_o;
   logic [CNT_W-1:0]       page_count_o;
   logic [MAX_PAGES*PPN_W-1:0] pa_list_o;
   logic [PPN_W-1:0]       gpr_ppn_o;

   sfw_walker #(
      .ADDR_W(ADDR_W), .FSZ_W(FSZ_W), .IDX_W(IDX_W), .XS_W(XS_W), .OWN_W(OWN_W),
      .SEG_W(SEG_W), .PPN_W(PPN_W), .MAX_PAGES(MAX_PAGES), .GPR_BYTES(GPR_BYTES)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode32_i(mode32_i),
      .save_ofs_i(save_ofs_i), .region_base_i(region_base_i), .frame_pages_i(frame_pages_i),
      .frame_idx_i(frame_idx_i), .xstate_size_i(xstate_size_i), .owner_id_i(owner_id_i),
      .ds_limit_i(ds_limit_i), .lk_req_valid_o(lk_req_valid_o), .lk_req_ready_i(lk_req_ready_i),
      .lk_req_page_o(lk_req_page_o), .lk_rsp_valid_i(lk_rsp_valid_i), .lk_rsp_prot_i(lk_rsp_prot_i),
      .lk_rsp_present_i(lk_rsp_present_i), .lk_rsp_blocked_i(lk_rsp_blocked_i),
      .lk_rsp_pending_i(lk_rsp_pending_i), .lk_rsp_modified_i(lk_rsp_modified_i),
      .lk_rsp_regular_i(lk_rsp_regular_i), .lk_rsp_rd_i(lk_rsp_rd_i), .lk_rsp_wr_i(lk_rsp_wr_i),
      .lk_rsp_lin_page_i(lk_rsp_lin_page_i), .lk_rsp_owner_i(lk_rsp_owner_i),
      .lk_rsp_ppn_i(lk_rsp_ppn_i), .busy_o(busy_o), .done_o(done_o), .pf_fault_o(pf_fault_o),
      .gp_fault_o(gp_fault_o), .fault_addr_o(fault_addr_o), .page_count_o(page_count_o),
      .pa_list_o(pa_list_o), .gpr_ppn_o(gpr_ppn_o)
   );

   int n_tests = 0;
   int n_fail  = 0;
   bit finished = 0;

   // reference model state
   longint unsigned exp_q[$];
   int  hs_n = 0;
   int  inj_idx = -1, inj_kind = 0, rsp_delay = 0, ready_gap = 0;
   int  rsp_cnt = -1, rsp_ord = 0;
   longint unsigned rsp_page = 0;
   logic [OWN_W-1:0] cfg_owner = '0;
   longint cyc = 0;

   function automatic logic [PPN_W-1:0] ppn_of(longint unsigned pg);
      return PPN_W'(pg * 5 + 3);
   endfunction

   task automatic chk(bit ok, string req, string what, longint unsigned act, longint unsigned expv);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
      end
   endtask

   // metadata responder and per-cycle request comparison
   initial begin
      forever begin
         @(negedge clk);
         cyc++;
         lk_rsp_valid_i = 0;
         if (rsp_cnt == 0) begin
            lk_rsp_valid_i    = 1;
            lk_rsp_prot_i     = 1; lk_rsp_present_i = 1; lk_rsp_blocked_i = 0;
            lk_rsp_pending_i  = 0; lk_rsp_modified_i = 0; lk_rsp_regular_i = 1;
            lk_rsp_rd_i       = 1; lk_rsp_wr_i = 1;
            lk_rsp_lin_page_i = LPG_W'(rsp_page);
            lk_rsp_owner_i    = cfg_owner;
            lk_rsp_ppn_i      = ppn_of(rsp_page);
            if (rsp_ord == inj_idx) begin
               case (inj_kind)
                  0: lk_rsp_prot_i     = 0;
                  1: lk_rsp_present_i  = 0;
                  2: lk_rsp_blocked_i  = 1;
                  3: lk_rsp_pending_i  = 1;
                  4: lk_rsp_modified_i = 1;
                  5: lk_rsp_regular_i  = 0;
                  6: lk_rsp_rd_i       = 0;
                  7: lk_rsp_wr_i       = 0;
                  8: lk_rsp_lin_page_i = lk_rsp_lin_page_i ^ 1;
                  default: lk_rsp_owner_i = lk_rsp_owner_i ^ 1;
               endcase
            end
            rsp_cnt = -1;
         end else if (rsp_cnt > 0) begin
            rsp_cnt--;
         end
         lk_req_ready_i = (ready_gap == 0) ? 1'b1 : ((cyc % (ready_gap + 1)) == 0);
         if (lk_req_valid_o && lk_req_ready_i) begin
            if (hs_n < exp_q.size())
               chk(longint'(lk_req_page_o) == exp_q[hs_n], "R1 R2 R6 R9", "request page",
                   longint'(lk_req_page_o), exp_q[hs_n]);
            else
               chk(0, "R5", "request after end of walk", longint'(lk_req_page_o), 0);
            rsp_ord  = hs_n;
            rsp_page = longint'(lk_req_page_o);
            hs_n++;
            rsp_cnt  = rsp_delay;
         end
      end
   end

   task automatic run_walk(input string tag, input longint unsigned ofs, input longint unsigned base,
                           input int fp, input int idx, input longint unsigned xs, input bit m32,
                           input longint unsigned dsl, input int inj_i, input int inj_k,
                           input int dly, input int gap, input bit poke);
      longint unsigned frame, gpr, raw, e_addr;
      int npg, total, e_cnt, wd;
      bit e_pf, e_gp;
      frame = (ofs + base + 4096 * longint'(fp) * longint'(idx)) & AMASK;
      gpr   = (frame + 4096 * longint'(fp) - GPR_BYTES) & AMASK;
      raw   = xs / 4096 + 1;
      npg   = (raw > MAX_PAGES) ? MAX_PAGES : int'(raw);
      exp_q.delete();
      for (int k = 0; k < npg; k++) exp_q.push_back(((frame + 4096 * k) & AMASK) >> 12);
      exp_q.push_back(gpr >> 12);
      total = npg + 1;
      if (inj_i >= 0 && inj_i < total) total = inj_i + 1;
      e_pf   = (inj_i >= 0) && (inj_i <= npg);
      e_gp   = !e_pf && m32 && ((gpr + GPR_BYTES - 1) > dsl);
      e_cnt  = (e_pf && inj_i < npg) ? inj_i : npg;
      e_addr = e_pf ? ((inj_i < npg) ? ((frame + 4096 * inj_i) & AMASK) : gpr) : (e_gp ? gpr : 0);

      inj_idx = inj_i; inj_kind = inj_k; rsp_delay = dly; ready_gap = gap;
      cfg_owner = OWN_W'(16'h3C5 + fp);
      hs_n = 0;

      @(negedge clk);
      save_ofs_i = ADDR_W'(ofs); region_base_i = ADDR_W'(base);
      frame_pages_i = FSZ_W'(fp); frame_idx_i = IDX_W'(idx); xstate_size_i = XS_W'(xs);
      mode32_i = m32; ds_limit_i = SEG_W'(dsl); owner_id_i = cfg_owner;
      start_i = 1;
      @(negedge clk);
      start_i = 0;
      if (poke) begin
         // a second start with different inputs while busy must be ignored
         chk(busy_o == 1'b1, "R10", "busy during walk", busy_o, 1);
         save_ofs_i = ADDR_W'(ofs + 64'h5000); frame_idx_i = IDX_W'(idx + 1); owner_id_i = ~cfg_owner;
         start_i = 1;
         @(negedge clk);
         start_i = 0;
      end
      wd = 0;
      while (!done_o && wd < 3000) begin
         @(negedge clk);
         wd++;
      end
      if (!done_o) begin
         chk(0, "R10", {tag, " walk watchdog"}, 0, 1);
         return;
      end
      chk(hs_n == total, "R5", {tag, " requests issued"}, hs_n, total);
      chk(pf_fault_o == e_pf, (inj_k >= 8) ? "R4" : "R3", {tag, " page fault"}, pf_fault_o, e_pf);
      chk(gp_fault_o == e_gp, "R7", {tag, " protection fault"}, gp_fault_o, e_gp);
      chk(longint'(fault_addr_o) == e_addr, "R3", {tag, " fault address"}, fault_addr_o, e_addr);
      chk(int'(page_count_o) == e_cnt, "R8", {tag, " page count"}, page_count_o, e_cnt);
      for (int s = 0; s < MAX_PAGES; s++) begin
         longint unsigned ev;
         ev = (s < e_cnt) ? longint'(ppn_of(((frame + 4096 * s) & AMASK) >> 12)) : 0;
         chk(longint'(pa_list_o[s*PPN_W +: PPN_W]) == ev, "R8", {tag, " captured page"},
             pa_list_o[s*PPN_W +: PPN_W], ev);
      end
      if (!e_pf)
         chk(gpr_ppn_o == ppn_of(gpr >> 12), "R6", {tag, " register-area page"},
             gpr_ppn_o, ppn_of(gpr >> 12));
      @(negedge clk);
      chk(done_o == 1'b0, "R10", {tag, " done pulse width"}, done_o, 0);
      repeat (3) @(negedge clk);
      chk(hs_n == total, "R5", {tag, " no request after end"}, hs_n, total);
      chk(pf_fault_o == e_pf && int'(page_count_o) == e_cnt, "R10", {tag, " results held"},
          page_count_o, e_cnt);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(!lk_req_valid_o && !done_o && !busy_o, "R11", "reset idle outputs",
          {lk_req_valid_o, done_o, busy_o}, 0);
      chk(!pf_fault_o && !gp_fault_o && page_count_o == 0 && pa_list_o == '0, "R11",
          "reset results", {pf_fault_o, gp_fault_o}, 0);
      rst_n = 1;
      repeat (2) @(negedge clk);
      chk(!lk_req_valid_o && !busy_o, "R11", "idle after reset release", lk_req_valid_o, 0);

      // R1: plain 64-bit walk, two frame pages
      run_walk("R1", 64'h3000, 64'h7F_0000_0000, 2, 3, 5000, 0, 0, -1, 0, 0, 0, 0);
      // R2: page count edges and the cap
      run_walk("R2 size0", 64'h1000, 64'h20_0000_0000, 1, 0, 0, 0, 0, -1, 0, 0, 0, 0);
      run_walk("R2 size4095", 64'h0, 64'h40_0000, 3, 2, 4095, 0, 0, -1, 0, 0, 0, 0);
      run_walk("R2 size4096", 64'h0, 64'h40_0000, 3, 2, 4096, 0, 0, -1, 0, 0, 0, 0);
      run_walk("R2 exact cap", 64'h8000, 64'h1_0000_0000, 20, 1, 15 * 4096, 0, 0, -1, 0, 0, 0, 0);
      run_walk("R2 over cap", 64'h8000, 64'h1_0000_0000, 32, 2, 100000, 0, 0, -1, 0, 0, 0, 0);
      // R3 and R4: each field corrupted at a different page
      for (int k = 0; k < 10; k++)
         run_walk((k >= 8) ? "R4 field" : "R3 field", 64'h2000, 64'h5_0000_0000, 4, k % 3,
                  2 * 4096 + 10, 0, 0, k % 3, k, k % 2, 0, 0);
      // R6: the register-area page itself fails
      run_walk("R6 gpr fault", 64'h2000, 64'h5_0000_0000, 4, 1, 4096, 0, 0, 2, 2, 0, 0, 0);
      run_walk("R6 gpr owner", 64'h2000, 64'h5_0000_0000, 4, 1, 0, 0, 0, 1, 9, 0, 0, 0);
      // R7: segment limit at the last byte and one below, both modes
      run_walk("R7 limit ok", 64'h2000, 64'h1000_0000, 1, 0, 0, 1, 64'h1000_2FFF, -1, 0, 0, 0, 0);
      run_walk("R7 limit short", 64'h2000, 64'h1000_0000, 1, 0, 0, 1, 64'h1000_2FFE, -1, 0, 0, 0, 0);
      run_walk("R7 64-bit ignore", 64'h2000, 64'h1000_0000, 1, 0, 0, 0, 64'h10, -1, 0, 0, 0, 0);
      run_walk("R7 pf wins", 64'h2000, 64'h1000_0000, 1, 0, 0, 1, 64'h10, 0, 6, 0, 0, 0);
      // R9: backpressure and slow responses
      run_walk("R9 slow", 64'h6000, 64'h33_0000_0000, 5, 2, 3 * 4096, 0, 0, -1, 0, 3, 2, 0);
      run_walk("R9 slow fault", 64'h6000, 64'h33_0000_0000, 5, 2, 3 * 4096, 0, 0, 3, 7, 2, 3, 0);
      // R10: start while busy is ignored
      run_walk("R10 poke", 64'h1000, 64'h9_0000_0000, 2, 1, 4096, 0, 0, -1, 0, 1, 1, 1);

      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      #(8 * 150000);
      if (!finished) begin
         n_tests++;
         n_fail++;
         $display("FAIL R10 global watchdog actual=running expected=finished");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule